// File: doc/BRIEF.md
# Set-Associative Translation Cache

This block caches page-table entries for a 32-bit virtual address space divided into 4 KB pages. It holds 16 sets of 4 ways. Each way holds either a leaf entry, which maps one page, or a directory entry, which covers a 4 MB region. A per-way flag tells the two kinds apart. A lookup takes a full virtual address. One cycle later the block returns a registered result with these parts:

- whether the leaf entry for that page is cached, and if so the entry and the physical address built from it;
- separately, whether the directory entry for the enclosing region is cached, and if so that entry.

A page-table walker uses the directory result to decide whether it must read one table level from memory or two. The walker also writes entries back through the fill port.

Software-driven maintenance takes three forms:

- A task-switch flush drops every entry whose global bit is clear.
- A full flush drops everything.
- A single-page invalidate drops the leaf entry of one page.

When a set is full, a fill replaces a way chosen by a per-set round-robin pointer. An invalid way is always used first.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses on both the leaf and the directory result, and `rsp_valid`, `rsp_hit` and `rsp_dir_hit` are low while reset is held.
- R2: A lookup presented with `req_valid` high in one cycle is answered in the next cycle with `rsp_valid` high. In a cycle that follows no request, `rsp_valid`, `rsp_hit` and `rsp_dir_hit` are all low.
- R3: On a leaf hit, `rsp_pte` is the cached entry and `rsp_pa` is entry bits 31..12 joined to address bits 11..0. On a leaf miss both are zero.
- R4: A leaf entry for page number V (address bits 31..12) lives in set V[3:0] with tag V[19:4]. An entry in the same set with a different tag does not hit.
- R5: A directory entry is keyed by K = V[19:10]. It is stored in set K[3:0] with tag K[9:4] zero-extended to 16 bits. Any page in the region raises `rsp_dir_hit` and returns the entry on `rsp_dir_entry` (zero when there is no directory hit). Because the kind flag (1 = directory, 0 = leaf) is part of the match, a directory entry never produces a leaf hit, and a leaf entry never produces a directory hit.
- R6: A fill into a set picks the lowest-numbered invalid way. Only when all four ways are valid does it evict the way named by that set's round-robin pointer. The pointer starts at way 0 after reset and advances by one, wrapping, only on such an eviction.
- R7: A fill whose kind and key are already cached overwrites that way in place. It evicts nothing and does not move the round-robin pointer.
- R8: The task-switch flush invalidates every entry whose bit 8 is 0 and keeps every entry whose bit 8 is 1.
- R9: The full flush invalidates every entry, whatever its bit 8.
- R10: A single-page invalidate clears only the leaf entry for that page number. The directory entry of its region and all other entries stay. An invalidate of a page that is not cached changes nothing.
- R11: Maintenance operations presented in the same cycle are served by priority: full flush, then task-switch flush, then invalidate, then fill. Lower-priority operations in that cycle are dropped. A lookup always sees the contents from before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Registered response valid, one cycle after the request |
| rsp_hit | output | 1 | Leaf entry for the page is cached |
| rsp_pte | output | 32 | Cached leaf entry, zero on miss |
| rsp_pa | output | 32 | Physical address on a leaf hit, zero on miss |
| rsp_dir_hit | output | 1 | Directory entry for the 4 MB region is cached |
| rsp_dir_entry | output | 32 | Cached directory entry, zero when absent |
| fill_valid | input | 1 | Write an entry from the walker |
| fill_dir | input | 1 | Kind of the filled entry: 1 directory, 0 leaf |
| fill_vpn | input | 20 | Page number the filled entry belongs to |
| fill_entry | input | 32 | Table entry to cache |
| inval_valid | input | 1 | Invalidate the leaf entry of one page |
| inval_vpn | input | 20 | Page number to invalidate |
| flush_task | input | 1 | Drop all entries whose bit 8 is clear |
| flush_all | input | 1 | Drop all entries |

## Verification
The hardest state to reach from the ports is a full set whose round-robin pointer has moved away from way 0. That state is needed to show that in-place refills and fills into an invalidated way leave the pointer alone. The stimulus fills five and more page numbers that share the low four bits. It then refills one of them in place and invalidates another. After each step it looks up every page in that set, so the evicted way shows itself as the single miss. Directory and leaf entries that land in the same set with equal stored tags are also constructed. This shows the kind flag keeps them apart.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   // maintenance operation applied to the entry arrays in one cycle
   typedef enum logic [2:0] {
      OP_IDLE,
      OP_FILL,
      OP_INVAL,
      OP_FLUSH_TASK,
      OP_FLUSH_ALL
   } xlat_op_e;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
   parameter int WAYS    = 4,
   parameter int TAG_W   = 16,
   parameter int ENTRY_W = 32,
   parameter int WAY_W   = 2
) (
   input  logic [WAYS-1:0]              row_vld,
   input  logic [WAYS-1:0]              row_dir,
   input  logic [WAYS-1:0][TAG_W-1:0]   row_tag,
   input  logic [WAYS-1:0][ENTRY_W-1:0] row_data,
   input  logic [TAG_W-1:0]             key_tag,
   input  logic                         key_dir,
   output logic                         hit,
   output logic [WAY_W-1:0]             way,
   output logic [ENTRY_W-1:0]           data
);
   logic [WAYS-1:0] eq;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign eq[w] = row_vld[w] && (row_dir[w] == key_dir) && (row_tag[w] == key_tag);
   end

   always_comb begin
      hit  = 1'b0;
      way  = '0;
      data = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (eq[w]) begin
            hit  = 1'b1;
            way  = WAY_W'(w);
            data = row_data[w];
         end
      end
   end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int SETS  = 16,
   parameter int WAYS  = 4,
   parameter int IDX_W = 4,
   parameter int WAY_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic [WAYS-1:0]  row_vld,
   input  logic             match_hit,
   input  logic [WAY_W-1:0] match_way,
   input  logic             commit,
   output logic [WAY_W-1:0] way
);
   logic [SETS-1:0][WAY_W-1:0] ptr;
   logic [WAY_W-1:0]           free_way;
   logic                       full;

   assign full = &row_vld;

   always_comb begin
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!row_vld[w]) free_way = WAY_W'(w);
      end
   end

   assign way = match_hit ? match_way : (full ? ptr[idx] : free_way);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (commit && !match_hit && full) begin
         ptr[idx] <= (ptr[idx] == WAY_W'(WAYS - 1)) ? '0 : ptr[idx] + 1'b1;
      end
   end

   // R6
   evict_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && row_vld[way]) |-> (match_hit || full));
endmodule

// File: rtl/xlat_store.sv
module xlat_store
   import xlat_pkg::*;
#(
   parameter int SETS       = 16,
   parameter int WAYS       = 4,
   parameter int IDX_W      = 4,
   parameter int TAG_W      = 16,
   parameter int ENTRY_W    = 32,
   parameter int WAY_W      = 2,
   parameter int GLOBAL_BIT = 8
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  xlat_op_e                               op,
   input  logic [IDX_W-1:0]                       wr_idx,
   input  logic [WAY_W-1:0]                       wr_way,
   input  logic [TAG_W-1:0]                       wr_tag,
   input  logic                                   wr_dir,
   input  logic [ENTRY_W-1:0]                     wr_data,
   input  logic [IDX_W-1:0]                       inv_idx,
   input  logic [WAY_W-1:0]                       inv_way,
   input  logic                                   inv_hit,
   output logic [SETS-1:0][WAYS-1:0]              vld,
   output logic [SETS-1:0][WAYS-1:0]              dir,
   output logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   tag,
   output logic [SETS-1:0][WAYS-1:0][ENTRY_W-1:0] data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld <= '0;
      end else begin
         unique case (op)
            OP_FLUSH_ALL: vld <= '0;
            OP_FLUSH_TASK: begin
               for (int s = 0; s < SETS; s++)
                  for (int w = 0; w < WAYS; w++)
                     if (!data[s][w][GLOBAL_BIT]) vld[s][w] <= 1'b0;
            end
            OP_INVAL: if (inv_hit) vld[inv_idx][inv_way] <= 1'b0;
            OP_FILL:  vld[wr_idx][wr_way] <= 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (op == OP_FILL) begin
         dir[wr_idx][wr_way]  <= wr_dir;
         tag[wr_idx][wr_way]  <= wr_tag;
         data[wr_idx][wr_way] <= wr_data;
      end
   end

   logic live_local;
   always_comb begin
      live_local = 1'b0;
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++)
            if (vld[s][w] && !data[s][w][GLOBAL_BIT]) live_local = 1'b1;
   end

   // R9
   full_flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_FLUSH_ALL) |=> (vld == '0));
   // R8
   task_flush_keeps_global_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_FLUSH_TASK) |=> !live_local);
   // R6
   fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_FILL) |=> (vld[$past(wr_idx)][$past(wr_way)] &&
                            tag[$past(wr_idx)][$past(wr_way)] == $past(wr_tag)));
   // R10
   inval_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_INVAL && inv_hit) |=> !vld[$past(inv_idx)][$past(inv_way)]);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int OFF_W      = 12,
   parameter int IDX_W      = 4,
   parameter int WAYS       = 4,
   parameter int DIR_KEY_W  = 10,
   parameter int ENTRY_W    = 32,
   parameter int GLOBAL_BIT = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [VA_W-1:0]         req_va,
   output logic                    rsp_valid,
   output logic                    rsp_hit,
   output logic [ENTRY_W-1:0]      rsp_pte,
   output logic [ENTRY_W-1:0]      rsp_pa,
   output logic                    rsp_dir_hit,
   output logic [ENTRY_W-1:0]      rsp_dir_entry,
   input  logic                    fill_valid,
   input  logic                    fill_dir,
   input  logic [VA_W-OFF_W-1:0]   fill_vpn,
   input  logic [ENTRY_W-1:0]      fill_entry,
   input  logic                    inval_valid,
   input  logic [VA_W-OFF_W-1:0]   inval_vpn,
   input  logic                    flush_task,
   input  logic                    flush_all
);
   localparam int VPN_W = VA_W - OFF_W;
   localparam int TAG_W = VPN_W - IDX_W;
   localparam int SETS  = 1 << IDX_W;
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("xlat_cache: WAYS must be a power of two, at least 2");
   end
   if (DIR_KEY_W < IDX_W || DIR_KEY_W > VPN_W) begin : g_bad_key
      $error("xlat_cache: DIR_KEY_W must lie between IDX_W and the page number width");
   end
   if (ENTRY_W <= OFF_W || GLOBAL_BIT >= ENTRY_W) begin : g_bad_entry
      $error("xlat_cache: entry too narrow for frame number or global bit");
   end

   function automatic logic [IDX_W-1:0] idx_of(input logic [VPN_W-1:0] v, input logic d);
      logic [DIR_KEY_W-1:0] k;
      k = v[VPN_W-1 -: DIR_KEY_W];
      return d ? k[IDX_W-1:0] : v[IDX_W-1:0];
   endfunction

   function automatic logic [TAG_W-1:0] tag_of(input logic [VPN_W-1:0] v, input logic d);
      logic [DIR_KEY_W-1:0] k;
      k = v[VPN_W-1 -: DIR_KEY_W];
      return d ? TAG_W'(k >> IDX_W) : v[VPN_W-1:IDX_W];
   endfunction

   logic [SETS-1:0][WAYS-1:0]              a_vld, a_dir;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   a_tag;
   logic [SETS-1:0][WAYS-1:0][ENTRY_W-1:0] a_data;

   logic [VPN_W-1:0] lk_vpn;
   logic [IDX_W-1:0] lk_idx, dk_idx, fl_idx, iv_idx;
   assign lk_vpn = req_va[VA_W-1:OFF_W];
   assign lk_idx = idx_of(lk_vpn, 1'b0);
   assign dk_idx = idx_of(lk_vpn, 1'b1);
   assign fl_idx = idx_of(fill_vpn, fill_dir);
   assign iv_idx = idx_of(inval_vpn, 1'b0);

   logic               l_hit, d_hit, f_hit, i_hit;
   logic [WAY_W-1:0]   l_way, d_way, f_way, i_way, v_way;
   logic [ENTRY_W-1:0] l_data, d_data, f_data, i_data;

   xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ENTRY_W(ENTRY_W), .WAY_W(WAY_W)) u_leaf_match (
      .row_vld(a_vld[lk_idx]), .row_dir(a_dir[lk_idx]), .row_tag(a_tag[lk_idx]),
      .row_data(a_data[lk_idx]), .key_tag(tag_of(lk_vpn, 1'b0)), .key_dir(1'b0),
      .hit(l_hit), .way(l_way), .data(l_data));

   xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ENTRY_W(ENTRY_W), .WAY_W(WAY_W)) u_dir_match (
      .row_vld(a_vld[dk_idx]), .row_dir(a_dir[dk_idx]), .row_tag(a_tag[dk_idx]),
      .row_data(a_data[dk_idx]), .key_tag(tag_of(lk_vpn, 1'b1)), .key_dir(1'b1),
      .hit(d_hit), .way(d_way), .data(d_data));

   xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ENTRY_W(ENTRY_W), .WAY_W(WAY_W)) u_fill_match (
      .row_vld(a_vld[fl_idx]), .row_dir(a_dir[fl_idx]), .row_tag(a_tag[fl_idx]),
      .row_data(a_data[fl_idx]), .key_tag(tag_of(fill_vpn, fill_dir)), .key_dir(fill_dir),
      .hit(f_hit), .way(f_way), .data(f_data));

   xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ENTRY_W(ENTRY_W), .WAY_W(WAY_W)) u_inval_match (
      .row_vld(a_vld[iv_idx]), .row_dir(a_dir[iv_idx]), .row_tag(a_tag[iv_idx]),
      .row_data(a_data[iv_idx]), .key_tag(tag_of(inval_vpn, 1'b0)), .key_dir(1'b0),
      .hit(i_hit), .way(i_way), .data(i_data));

   xlat_op_e op;
   always_comb begin
      if (flush_all)        op = OP_FLUSH_ALL;
      else if (flush_task)  op = OP_FLUSH_TASK;
      else if (inval_valid) op = OP_INVAL;
      else if (fill_valid)  op = OP_FILL;
      else                  op = OP_IDLE;
   end

   xlat_victim #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_victim (
      .clk(clk), .rst_n(rst_n), .idx(fl_idx), .row_vld(a_vld[fl_idx]),
      .match_hit(f_hit), .match_way(f_way), .commit(op == OP_FILL), .way(v_way));

   xlat_store #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .TAG_W(TAG_W), .ENTRY_W(ENTRY_W),
                .WAY_W(WAY_W), .GLOBAL_BIT(GLOBAL_BIT)) u_store (
      .clk(clk), .rst_n(rst_n), .op(op),
      .wr_idx(fl_idx), .wr_way(v_way), .wr_tag(tag_of(fill_vpn, fill_dir)),
      .wr_dir(fill_dir), .wr_data(fill_entry),
      .inv_idx(iv_idx), .inv_way(i_way), .inv_hit(i_hit),
      .vld(a_vld), .dir(a_dir), .tag(a_tag), .data(a_data));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_hit       <= 1'b0;
         rsp_pte       <= '0;
         rsp_pa        <= '0;
         rsp_dir_hit   <= 1'b0;
         rsp_dir_entry <= '0;
      end else begin
         rsp_valid     <= req_valid;
         rsp_hit       <= req_valid && l_hit;
         rsp_pte       <= (req_valid && l_hit) ? l_data : '0;
         rsp_pa        <= (req_valid && l_hit) ?
                          {l_data[ENTRY_W-1:OFF_W], req_va[OFF_W-1:0]} : '0;
         rsp_dir_hit   <= req_valid && d_hit;
         rsp_dir_entry <= (req_valid && d_hit) ? d_data : '0;
      end
   end

   // R2
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R2
   quiet_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_dir_hit));
   // R3
   pa_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (rsp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0])));
   // R3
   pa_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (rsp_pa[ENTRY_W-1:OFF_W] == rsp_pte[ENTRY_W-1:OFF_W]));
endmodule

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0;
   logic        rsp_valid, rsp_hit, rsp_dir_hit;
   logic [31:0] rsp_pte, rsp_pa, rsp_dir_entry;
   logic        fill_valid = 1'b0, fill_dir = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [31:0] fill_entry = '0;
   logic        inval_valid = 1'b0;
   logic [19:0] inval_vpn = '0;
   logic        flush_task = 1'b0, flush_all = 1'b0;

   int nchk = 0;
   int nfail = 0;

   always #4 clk = ~clk;

   xlat_cache u_xlat_cache (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pte(rsp_pte), .rsp_pa(rsp_pa),
      .rsp_dir_hit(rsp_dir_hit), .rsp_dir_entry(rsp_dir_entry),
      .fill_valid(fill_valid), .fill_dir(fill_dir), .fill_vpn(fill_vpn),
      .fill_entry(fill_entry), .inval_valid(inval_valid), .inval_vpn(inval_vpn),
      .flush_task(flush_task), .flush_all(flush_all));

   typedef struct packed {
      logic [1:0]  kind;   // 0 lookup, 1 leaf fill, 2 directory fill
      logic [19:0] vpn;
      logic [11:0] off;
      logic [31:0] ent;
      logic        eh;
      logic [31:0] ep;
      logic        edh;
      logic [31:0] ed;
   } vec_t;

   localparam vec_t TBL [9] = '{
      '{2'd1, 20'h12345, 12'h000, 32'hABCDE007, 1'b0, 32'h0,        1'b0, 32'h0},        // leaf fill
      '{2'd0, 20'h12345, 12'h9A4, 32'h0,        1'b1, 32'hABCDE007, 1'b0, 32'h0},        // R3 hit
      '{2'd0, 20'h12355, 12'h010, 32'h0,        1'b0, 32'h0,        1'b0, 32'h0},        // R4 tag differs
      '{2'd2, 20'h12345, 12'h000, 32'h00FED003, 1'b0, 32'h0,        1'b0, 32'h0},        // dir fill
      '{2'd0, 20'h12345, 12'h004, 32'h0,        1'b1, 32'hABCDE007, 1'b1, 32'h00FED003}, // R5 both
      '{2'd0, 20'h12000, 12'hFFF, 32'h0,        1'b0, 32'h0,        1'b1, 32'h00FED003}, // R5 region
      '{2'd0, 20'h00048, 12'h000, 32'h0,        1'b0, 32'h0,        1'b0, 32'h0},        // R5 kind flag
      '{2'd1, 20'h00048, 12'h000, 32'h55555100, 1'b0, 32'h0,        1'b0, 32'h0},        // global leaf
      '{2'd0, 20'h00048, 12'h321, 32'h0,        1'b1, 32'h55555100, 1'b0, 32'h0}         // R4 hit
   };

   task automatic look(input string rq, input logic [19:0] vpn, input logic [11:0] off,
                       input logic eh, input logic [31:0] ep,
                       input logic edh, input logic [31:0] ed);
      logic [31:0] xpte, xpa, xd;
      @(negedge clk);
      req_valid = 1'b1;
      req_va = {vpn, off};
      @(negedge clk);
      req_valid = 1'b0;
      xpte = eh ? ep : 32'h0;
      xpa  = eh ? {ep[31:12], off} : 32'h0;
      xd   = edh ? ed : 32'h0;
      nchk++;
      if (rsp_valid !== 1'b1 || rsp_hit !== eh || rsp_pte !== xpte || rsp_pa !== xpa ||
          rsp_dir_hit !== edh || rsp_dir_entry !== xd) begin
         nfail++;
         $display("FAIL %s vpn=%h: got v=%b hit=%b pte=%h pa=%h dh=%b de=%h, exp v=1 hit=%b pte=%h pa=%h dh=%b de=%h",
                  rq, vpn, rsp_valid, rsp_hit, rsp_pte, rsp_pa, rsp_dir_hit, rsp_dir_entry,
                  eh, xpte, xpa, edh, xd);
      end
   endtask

   task automatic drive(input logic fv, input logic fd, input logic [19:0] fvpn,
                        input logic [31:0] fent, input logic iv, input logic [19:0] ivpn,
                        input logic ft, input logic fa);
      @(negedge clk);
      fill_valid = fv; fill_dir = fd; fill_vpn = fvpn; fill_entry = fent;
      inval_valid = iv; inval_vpn = ivpn; flush_task = ft; flush_all = fa;
      @(negedge clk);
      fill_valid = 1'b0; inval_valid = 1'b0; flush_task = 1'b0; flush_all = 1'b0;
   endtask

   task automatic fill(input logic d, input logic [19:0] v, input logic [31:0] e);
      drive(1'b1, d, v, e, 1'b0, 20'h0, 1'b0, 1'b0);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      nchk++;
      if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_dir_hit !== 1'b0) begin
         nfail++;
         $display("FAIL R1 in reset: got v=%b hit=%b dh=%b exp 0 0 0", rsp_valid, rsp_hit, rsp_dir_hit);
      end
      rst_n = 1'b1;
      look("R1 empty after reset", 20'h12345, 12'h000, 1'b0, 32'h0, 1'b0, 32'h0);
      @(negedge clk);
      nchk++;
      if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
         nfail++;
         $display("FAIL R2 idle: got v=%b hit=%b exp 0 0", rsp_valid, rsp_hit);
      end

      for (int i = 0; i < 9; i++) begin
         case (TBL[i].kind)
            2'd1: fill(1'b0, TBL[i].vpn, TBL[i].ent);
            2'd2: fill(1'b1, TBL[i].vpn, TBL[i].ent);
            default: look("R3/R4/R5 table", TBL[i].vpn, TBL[i].off, TBL[i].eh, TBL[i].ep,
                          TBL[i].edh, TBL[i].ed);
         endcase
      end

      // R7 refill in place
      fill(1'b0, 20'h12345, 32'h11111000);
      look("R7 refill", 20'h12345, 12'h0AB, 1'b1, 32'h11111000, 1'b1, 32'h00FED003);

      // R8 task flush
      drive(1'b0, 1'b0, 20'h0, 32'h0, 1'b0, 20'h0, 1'b1, 1'b0);
      look("R8 local dropped", 20'h12345, 12'h000, 1'b0, 32'h0, 1'b0, 32'h0);
      look("R8 global kept", 20'h00048, 12'h001, 1'b1, 32'h55555100, 1'b0, 32'h0);

      // R10 single-page invalidate
      fill(1'b0, 20'h12345, 32'h22222000);
      fill(1'b1, 20'h12345, 32'h00FED003);
      drive(1'b0, 1'b0, 20'h0, 32'h0, 1'b1, 20'h12345, 1'b0, 1'b0);
      look("R10 leaf gone dir kept", 20'h12345, 12'h000, 1'b0, 32'h0, 1'b1, 32'h00FED003);
      drive(1'b0, 1'b0, 20'h0, 32'h0, 1'b1, 20'h00049, 1'b0, 1'b0);
      look("R10 absent page no effect", 20'h00048, 12'h000, 1'b1, 32'h55555100, 1'b0, 32'h0);

      // R9 full flush
      drive(1'b0, 1'b0, 20'h0, 32'h0, 1'b0, 20'h0, 1'b0, 1'b1);
      look("R9 global dropped", 20'h00048, 12'h000, 1'b0, 32'h0, 1'b0, 32'h0);
      look("R9 dir dropped", 20'h12000, 12'h000, 1'b0, 32'h0, 1'b0, 32'h0);

      // R6 replacement in set 3
      fill(1'b0, 20'h00013, 32'h01300000);
      fill(1'b0, 20'h00023, 32'h02300000);
      fill(1'b0, 20'h00033, 32'h03300000);
      fill(1'b0, 20'h00043, 32'h04300000);
      look("R6 four ways", 20'h00013, 12'h000, 1'b1, 32'h01300000, 1'b0, 32'h0);
      look("R6 four ways", 20'h00043, 12'h000, 1'b1, 32'h04300000, 1'b0, 32'h0);
      fill(1'b0, 20'h00053, 32'h05300000);
      look("R6 way0 evicted", 20'h00013, 12'h000, 1'b0, 32'h0, 1'b0, 32'h0);
      look("R6 way1 kept", 20'h00023, 12'h000, 1'b1, 32'h02300000, 1'b0, 32'h0);
      look("R6 new present", 20'h00053, 12'h000, 1'b1, 32'h05300000, 1'b0, 32'h0);
      fill(1'b0, 20'h00063, 32'h06300000);
      look("R6 way1 evicted", 20'h00023, 12'h000, 1'b0, 32'h0, 1'b0, 32'h0);
      look("R6 way2 kept", 20'h00033, 12'h000, 1'b1, 32'h03300000, 1'b0, 32'h0);
      fill(1'b0, 20'h00033, 32'h03311000);
      look("R7 in place no evict", 20'h00053, 12'h000, 1'b1, 32'h05300000, 1'b0, 32'h0);
      look("R7 in place no evict", 20'h00043, 12'h000, 1'b1, 32'h04300000, 1'b0, 32'h0);
      fill(1'b0, 20'h00073, 32'h07300000);
      look("R7 pointer not moved", 20'h00033, 12'h000, 1'b0, 32'h0, 1'b0, 32'h0);
      look("R6 way3 kept", 20'h00043, 12'h000, 1'b1, 32'h04300000, 1'b0, 32'h0);
      drive(1'b0, 1'b0, 20'h0, 32'h0, 1'b1, 20'h00043, 1'b0, 1'b0);
      fill(1'b0, 20'h00083, 32'h08300000);
      look("R6 invalid way first", 20'h00053, 12'h000, 1'b1, 32'h05300000, 1'b0, 32'h0);
      look("R6 invalid way first", 20'h00063, 12'h000, 1'b1, 32'h06300000, 1'b0, 32'h0);
      look("R6 invalid way first", 20'h00073, 12'h000, 1'b1, 32'h07300000, 1'b0, 32'h0);
      fill(1'b0, 20'h00093, 32'h09300000);
      look("R6 pointer at way3", 20'h00083, 12'h000, 1'b0, 32'h0, 1'b0, 32'h0);
      look("R6 way0 kept", 20'h00053, 12'h000, 1'b1, 32'h05300000, 1'b0, 32'h0);

      // R11 same-cycle priority
      drive(1'b1, 1'b0, 20'hA0001, 32'h77777100, 1'b0, 20'h0, 1'b0, 1'b1);
      look("R11 fill vs full flush", 20'hA0001, 12'h000, 1'b0, 32'h0, 1'b0, 32'h0);
      drive(1'b1, 1'b0, 20'hA0001, 32'h77777100, 1'b0, 20'h0, 1'b1, 1'b0);
      look("R11 fill vs task flush", 20'hA0001, 12'h000, 1'b0, 32'h0, 1'b0, 32'h0);
      drive(1'b1, 1'b0, 20'hA0001, 32'h77777100, 1'b1, 20'h00005, 1'b0, 1'b0);
      look("R11 fill vs invalidate", 20'hA0001, 12'h000, 1'b0, 32'h0, 1'b0, 32'h0);
      fill(1'b0, 20'hA0001, 32'h77777100);
      look("R11 fill alone", 20'hA0001, 12'h5A5, 1'b1, 32'h77777100, 1'b0, 32'h0);

      summary();
   end
endmodule